// File: doc/BRIEF.md
# Simultaneous-Sample Converter Serial Output Port

This block is the digital sequencer and serial output stage of a six-channel converter that samples all of its channels at once. A rising edge on the convert strobe freezes the six channel codes presented by the converter core. The block then walks through the enabled channels at sixteen serial-clock rising edges per channel. At the end of each channel's slot it writes that channel's result latch.

While a sequence runs, the serial data line carries the results stored by the previous sequence, channel 0 first. Each slot holds a twelve-bit word sent MSB first, two filler bits and two released (high-impedance) clocks. The block also drives an output-enable that an external three-state pad uses.

All logic runs on a fast system clock. The serial clock and the convert strobe are sampled inputs whose rising edges the block detects. The three-bit channel-count field and the polarity-mode input are captured when a sequence starts and are held until it ends.

Top module: `adc_sop_port`

## Requirements
- R1: A rising edge of `conv_i` that is accepted copies all six channel codes from `codes_i` (channel c at bits [12c+11:12c]) into the block in the same system clock. Changes to `codes_i` after that edge have no effect on the results of that sequence.
- R2: A rising edge of `conv_i` that arrives while a sequence is running is ignored. The running sequence and its output stream continue unchanged until its last serial clock edge.
- R3: The channel count n comes from `sel_i`. Values 0 to 4 give n = `sel_i`+1, enabling channels 0..n-1. Values 5, 6 and 7 enable all six channels.
- R4: A sequence lasts exactly 16·n rising edges of `sck_i`, which is 96 for six channels. After it, every further `sck_i` rising edge leaves `sdo_oe_o` low until a new sequence is accepted.
- R5: Counting `sck_i` rising edges from 1 after an accepted strobe, `sdo_oe_o` is low after edges 1 and 2. The first data bit is driven after edge 3.
- R6: Slot s spans edges 16s+3 to 16s+18. Its first 12 edges drive bit 11 down to bit 0 of channel s's word. The next 2 edges keep `sdo_oe_o` high with filler data, and the last 2 drive `sdo_oe_o` low.
- R7: The word sent for channel s is the result latched by the most recent earlier sequence that converted channel s. Channel s's latch is written when edge 16(s+1) of the current sequence arrives, so a channel that is not enabled keeps its old result.
- R8: The core delivers offset-binary codes. With the captured mode bit high, the stored result is the two's complement form (bit 11 inverted). With it low, the stored result is the code unchanged (straight binary).
- R9: After reset all result latches hold zero and `sdo_oe_o` stays low until the first accepted strobe.
- R10: `sdo_o` and `sdo_oe_o` change only on a system clock in which a rising edge of `sck_i` is detected.
- R11: `sel_i` and `bip_i` are captured at the accepted strobe. Changing them during a sequence does not alter its length or the format of its results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers use its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Convert strobe; a rising edge starts a sequence when the block is idle |
| sck_i | input | 1 | Serial clock; each rising edge advances the sequence |
| sel_i | input | 3 | Channel-count code |
| bip_i | input | 1 | Polarity mode: 1 gives two's complement results, 0 gives straight binary |
| codes_i | input | 72 | Six 12-bit channel codes from the converter core, channel 0 in the low bits |
| sdo_o | output | 1 | Serial data, driven low while the enable is low |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |

## Verification
On every cycle the assertions check four things:
- the output is held steady between serial clock edges;
- the output stays released before the first strobe;
- the lead-in clocks of each sequence are released, and each slot's filler and gap positions follow the slot layout;
- a sequence ends after exactly sixteen edges per enabled channel, as decoded from the channel-count code captured at the strobe.

The data values on the line can only be shown by the bench's scenarios. These include words carried over from older sequences when the channel count shrinks and then grows, the MSB inversion in two's complement mode, and strobes that arrive during a sequence while the codes, count code and mode change. The scenarios also cover the released output on idle clocks after a short sequence.

// File: rtl/adc_sop_pkg.sv
`timescale 1ns/1ps
package adc_sop_pkg;

   // Position of one serial clock edge inside a slot.
   typedef enum logic [1:0] {
      PH_GAP  = 2'd0,
      PH_DATA = 2'd1,
      PH_FILL = 2'd2
   } slot_phase_e;

   // Number of enabled channels for a count code; codes past the last
   // channel saturate at the full channel count.
   function automatic int count_of_sel(input int sel, input int nch);
      return (sel >= nch - 1) ? nch : sel + 1;
   endfunction

endpackage

// File: rtl/adc_sop_ctrl.sv
`timescale 1ns/1ps
module adc_sop_ctrl #(
   parameter int NCH  = 6,
   parameter int SLOT = 16,
   parameter int SELW = 3,
   parameter int CW   = $clog2(NCH*SLOT+1),
   parameter int NW   = $clog2(NCH+1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            conv_i,
   input  logic            sck_i,
   input  logic [SELW-1:0] sel_i,
   input  logic            bip_i,
   output logic            start_o,
   output logic            step_o,
   output logic            hush_o,
   output logic            busy_o,
   output logic            bip_o,
   output logic [CW-1:0]   cnt_o,
   output logic [NW-1:0]   nch_o,
   output logic [NCH-1:0]  wr_o
);
   import adc_sop_pkg::*;

   logic            conv_q, sck_q, busy_q, bip_q;
   logic            conv_rise, sck_rise;
   logic [CW-1:0]   cnt_q, cnt_nxt, end_cnt;
   logic [NW-1:0]   nch_q, nch_dec;

   assign conv_rise = conv_i & ~conv_q;
   assign sck_rise  = sck_i & ~sck_q;
   assign start_o   = conv_rise & ~busy_q;
   assign step_o    = sck_rise & busy_q;
   assign hush_o    = sck_rise & ~busy_q;
   assign cnt_nxt   = cnt_q + CW'(1);
   assign end_cnt   = CW'(SLOT * int'(nch_q));

   always_comb nch_dec = NW'(count_of_sel(int'(sel_i), NCH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q <= 1'b0;
         sck_q  <= 1'b0;
         busy_q <= 1'b0;
         bip_q  <= 1'b0;
         cnt_q  <= '0;
         nch_q  <= NW'(1);
      end else begin
         conv_q <= conv_i;
         sck_q  <= sck_i;
         if (start_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            nch_q  <= nch_dec;
            bip_q  <= bip_i;
         end else if (step_o) begin
            cnt_q <= cnt_nxt;
            if (cnt_nxt == end_cnt)
               busy_q <= 1'b0;
         end
      end
   end

   // One write strobe per channel at the last edge of its slot.
   for (genvar c = 0; c < NCH; c++) begin : g_wr
      assign wr_o[c] = step_o && (cnt_nxt == CW'(SLOT*(c+1)));
   end

   assign busy_o = busy_q;
   assign bip_o  = bip_q;
   assign cnt_o  = cnt_nxt;
   assign nch_o  = nch_q;
endmodule

// File: rtl/adc_sop_bank.sv
`timescale 1ns/1ps
module adc_sop_bank #(
   parameter int NCH = 6,
   parameter int DW  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              bip_i,
   input  logic [NCH-1:0]    wr_i,
   input  logic [NCH*DW-1:0] codes_i,
   output logic [NCH*DW-1:0] lat_o
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [DW-1:0] snap_q, lat_q, fmt;

      // Offset binary to two's complement is an MSB inversion.
      assign fmt = bip_i ? {~snap_q[DW-1], snap_q[DW-2:0]} : snap_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            snap_q <= '0;
            lat_q  <= '0;
         end else begin
            if (start_i)
               snap_q <= codes_i[c*DW +: DW];
            if (wr_i[c])
               lat_q <= fmt;
         end
      end

      assign lat_o[c*DW +: DW] = lat_q;
   end
endmodule

// File: rtl/adc_sop_out.sv
`timescale 1ns/1ps
module adc_sop_out #(
   parameter int NCH  = 6,
   parameter int DW   = 12,
   parameter int SLOT = 16,
   parameter int CW   = $clog2(NCH*SLOT+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              hush_i,
   input  logic [CW-1:0]     cnt_i,
   input  logic [NCH*DW-1:0] lat_i,
   output logic              sdo_o,
   output logic              sdo_oe_o
);
   import adc_sop_pkg::*;

   localparam int HZ  = (SLOT - DW) / 2;
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int BW  = (DW > 1) ? $clog2(DW) : 1;

   logic [DW-1:0] words [NCH];
   slot_phase_e   phase;
   logic [CHW-1:0] ch_idx;
   logic [BW-1:0]  bit_idx;
   logic           nxt_oe, nxt_bit, sdo_q, oe_q;

   for (genvar c = 0; c < NCH; c++) begin : g_unpack
      assign words[c] = lat_i[c*DW +: DW];
   end

   always_comb begin
      int k, s, q;
      phase   = PH_GAP;
      ch_idx  = '0;
      bit_idx = '0;
      k = int'(cnt_i) - HZ - 1;
      s = (k >= 0) ? k / SLOT : 0;
      q = (k >= 0) ? k % SLOT : 0;
      if (k >= 0 && s < NCH) begin
         ch_idx  = CHW'(s);
         if (q < DW) begin
            phase   = PH_DATA;
            bit_idx = BW'(DW - 1 - q);
         end else if (q < SLOT - HZ) begin
            phase = PH_FILL;
         end
      end
   end

   assign nxt_oe  = (phase != PH_GAP);
   assign nxt_bit = (phase == PH_DATA) ? words[ch_idx][bit_idx] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q  <= 1'b0;
         sdo_q <= 1'b0;
      end else if (step_i) begin
         oe_q  <= nxt_oe;
         sdo_q <= nxt_bit;
      end else if (hush_i) begin
         oe_q  <= 1'b0;
         sdo_q <= 1'b0;
      end
   end

   assign sdo_o    = sdo_q;
   assign sdo_oe_o = oe_q;
endmodule

// File: rtl/adc_sop_port.sv
`timescale 1ns/1ps
module adc_sop_port #(
   parameter int NCH  = 6,
   parameter int DW   = 12,
   parameter int SLOT = 16,
   parameter int SELW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_i,
   input  logic              sck_i,
   input  logic [SELW-1:0]   sel_i,
   input  logic              bip_i,
   input  logic [NCH*DW-1:0] codes_i,
   output logic              sdo_o,
   output logic              sdo_oe_o
);
   localparam int CW = $clog2(NCH*SLOT+1);
   localparam int NW = $clog2(NCH+1);

   if (SLOT < DW + 2 || ((SLOT - DW) % 2) != 0) begin : g_bad_slot
      $error("SLOT must exceed DW by an even count of at least two");
   end
   if ((1 << SELW) < NCH) begin : g_bad_sel
      $error("SELW too narrow to enable every channel");
   end
   if (DW < 2 || NCH < 1) begin : g_bad_size
      $error("DW must be at least 2 and NCH at least 1");
   end

   logic            start, step, hush, busy, bip_cap;
   logic [CW-1:0]   cnt;
   logic [NW-1:0]   nch;
   logic [NCH-1:0]  wr;
   logic [NCH*DW-1:0] lat;

   adc_sop_ctrl #(.NCH(NCH), .SLOT(SLOT), .SELW(SELW), .CW(CW), .NW(NW)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .sck_i(sck_i),
      .sel_i(sel_i), .bip_i(bip_i),
      .start_o(start), .step_o(step), .hush_o(hush), .busy_o(busy),
      .bip_o(bip_cap), .cnt_o(cnt), .nch_o(nch), .wr_o(wr)
   );

   adc_sop_bank #(.NCH(NCH), .DW(DW)) i_bank (
      .clk(clk), .rst_n(rst_n), .start_i(start), .bip_i(bip_cap),
      .wr_i(wr), .codes_i(codes_i), .lat_o(lat)
   );

   adc_sop_out #(.NCH(NCH), .DW(DW), .SLOT(SLOT), .CW(CW)) i_out (
      .clk(clk), .rst_n(rst_n), .step_i(step), .hush_i(hush),
      .cnt_i(cnt), .lat_i(lat), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
   );
endmodule

// File: rtl/adc_sop_chk.sv
`timescale 1ns/1ps
module adc_sop_chk #(
   parameter int NCH  = 6,
   parameter int DW   = 12,
   parameter int SLOT = 16,
   parameter int SELW = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_i,
   input logic            sck_i,
   input logic [SELW-1:0] sel_i,
   input logic            sdo_o,
   input logic            sdo_oe_o,
   input logic            busy
);
   import adc_sop_pkg::*;

   localparam int HZ = (SLOT - DW) / 2;

   logic sck_d, conv_d, seen;
   logic sck_rise, conv_rise;
   int   ecnt, n_exp, pos;

   assign sck_rise  = sck_i & ~sck_d;
   assign conv_rise = conv_i & ~conv_d;
   assign pos       = (ecnt > HZ) ? (ecnt - HZ - 1) % SLOT : 0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d  <= 1'b0;
         conv_d <= 1'b0;
         seen   <= 1'b0;
         ecnt   <= 0;
         n_exp  <= 1;
      end else begin
         sck_d  <= sck_i;
         conv_d <= conv_i;
         if (conv_rise && !busy) begin
            seen  <= 1'b1;
            ecnt  <= 0;
            n_exp <= count_of_sel(int'(sel_i), NCH);
         end else if (sck_rise && busy) begin
            ecnt <= ecnt + 1;
         end
      end
   end

   // R9
   quiet_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> !sdo_oe_o);

   // R10
   hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_rise |=> ($stable(sdo_oe_o) && $stable(sdo_o)));

   // R3
   seq_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (ecnt == SLOT * n_exp));

   // R5
   lead_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ecnt >= 1 && ecnt <= HZ) |-> !sdo_oe_o);

   // R6
   slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ecnt > HZ && pos >= DW && pos < SLOT - HZ) |-> sdo_oe_o);

   // R6
   slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ecnt > HZ && pos >= SLOT - HZ) |-> !sdo_oe_o);
endmodule

bind adc_sop_port adc_sop_chk #(.NCH(NCH), .DW(DW), .SLOT(SLOT), .SELW(SELW)) i_chk (
   .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .sck_i(sck_i), .sel_i(sel_i),
   .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .busy(busy)
);

// File: tb/test_adc_sop_port.sv
`timescale 1ns/1ps
module test_adc_sop_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_i = 1'b0;
   logic        sck_i = 1'b0;
   logic [2:0]  sel_i = 3'd0;
   logic        bip_i = 1'b0;
   logic [71:0] codes_i;
   logic        sdo_o, sdo_oe_o;

   logic [11:0] codes [6];
   logic [11:0] mlat  [6];
   string       mtag  [6];

   typedef struct {
      bit    oe;
      bit    val;
      bit    care;
      string tag;
   } exp_t;
   exp_t expq[$];

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   always_comb
      for (int c = 0; c < 6; c++) codes_i[c*12 +: 12] = codes[c];

   adc_sop_port i_adc_sop_port (
      .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .sck_i(sck_i),
      .sel_i(sel_i), .bip_i(bip_i), .codes_i(codes_i),
      .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [11:0] code_of(input int set, input int ch);
      return 12'((set * 1447 + ch * 2731 + 613) ^ (set * 97));
   endfunction

   function automatic logic [11:0] fmt(input logic [11:0] c, input bit bip);
      return bip ? {~c[11], c[10:0]} : c;
   endfunction

   task automatic load_codes(input int set);
      for (int c = 0; c < 6; c++) codes[c] = code_of(set, c);
   endtask

   task automatic push(input bit oe, input bit val, input bit care, input string tag);
      exp_t it;
      it.oe = oe; it.val = val; it.care = care; it.tag = tag;
      expq.push_back(it);
   endtask

   task automatic sck_pulse();
      @(negedge clk) sck_i = 1'b1;
      repeat (2) @(negedge clk);
      sck_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic conv_pulse();
      @(negedge clk) conv_i = 1'b1;
      repeat (2) @(negedge clk);
      conv_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic idle_edges(input int k, input string tag);
      for (int i = 0; i < k; i++) begin
         push(1'b0, 1'b0, 1'b0, tag);
         sck_pulse();
      end
   endtask

   // Driver: starts a sequence and queues the expected line state per edge.
   task automatic run_seq(input logic [2:0] sel, input bit bip,
                          input string ltag, input bit disturb);
      logic [11:0] snap [6];
      int n;
      sel_i = sel;
      bip_i = bip;
      for (int c = 0; c < 6; c++) snap[c] = codes[c];
      conv_pulse();
      n = (sel >= 3'd5) ? 6 : int'(sel) + 1;
      for (int e = 1; e <= 16*n; e++) begin
         bit late;
         late = disturb && (e >= 20);
         if (disturb && e == 20) begin
            // R2 / R11 / R1: strobe, codes, count and mode change mid-sequence
            load_codes(9);
            sel_i = ~sel;
            bip_i = ~bip;
            conv_pulse();
         end
         if (e <= 2) begin
            push(1'b0, 1'b0, 1'b0, "R5");
         end else begin
            int k, s, q;
            k = e - 3; s = k / 16; q = k % 16;
            if (q < 12)      push(1'b1, mlat[s][11-q], 1'b1, late ? "R2" : mtag[s]);
            else if (q < 14) push(1'b1, 1'b0, 1'b0, late ? "R2" : "R6");
            else             push(1'b0, 1'b0, 1'b0, late ? "R2" : "R6");
         end
         sck_pulse();
         if (e % 16 == 0) begin
            mlat[e/16 - 1] = fmt(snap[e/16 - 1], bip);
            mtag[e/16 - 1] = bip ? {ltag, " R8"} : ltag;
         end
      end
   endtask

   // Monitor: pops one expected item per serial clock edge and compares.
   initial begin
      forever begin
         exp_t it;
         bit   h_oe, h_v;
         @(posedge sck_i);
         #1;
         @(negedge clk);
         if (expq.size() == 0) begin
            check(1'b0, "R4", "unexpected edge", 0, 1);
         end else begin
            it = expq.pop_front();
            check(sdo_oe_o == it.oe, it.tag, "sdo_oe_o", int'(sdo_oe_o), int'(it.oe));
            if (it.oe && it.care)
               check(sdo_o == it.val, it.tag, "sdo_o", int'(sdo_o), int'(it.val));
            h_oe = sdo_oe_o;
            h_v  = sdo_o;
            @(negedge sck_i);
            @(negedge clk);
            // R10: nothing moves while the serial clock is low
            check(sdo_oe_o == h_oe && sdo_o == h_v, "R10", "hold after falling edge",
                  int'({sdo_oe_o, sdo_o}), int'({h_oe, h_v}));
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < 6; c++) begin
         mlat[c] = 12'd0;
         mtag[c] = "R9";
      end
      load_codes(1);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(sdo_oe_o == 1'b0, "R9", "oe after reset", int'(sdo_oe_o), 0);
      idle_edges(3, "R9");

      // Full sequence; reads the zero latches left by reset.
      run_seq(3'd5, 1'b0, "R7", 1'b0);
      // Two's complement mode with a mid-sequence strobe and input changes.
      load_codes(2);
      run_seq(3'd7, 1'b1, "R1 R11", 1'b1);
      // Two channels, then idle edges stay released.
      load_codes(4);
      run_seq(3'd1, 1'b0, "R3", 1'b0);
      idle_edges(2, "R3");
      // Four channels: ch0,1 from the short run, ch2,3 from the older one.
      load_codes(5);
      run_seq(3'd3, 1'b1, "R7", 1'b0);
      // Single channel back to back.
      load_codes(6);
      run_seq(3'd0, 1'b0, "R3", 1'b0);
      idle_edges(2, "R3");
      // Saturated count code reads everything out.
      load_codes(7);
      run_seq(3'd6, 1'b0, "R4", 1'b0);
      idle_edges(2, "R4");

      repeat (6) @(negedge clk);
      check(expq.size() == 0, "R4", "queue drained", expq.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule